// File: doc/BRIEF.md
# Microsequence Integrity Checker

This monitor sits beside a microprogrammed control unit and watches every fetch. Each fetched microinstruction carries a control field, a Berger check value over that field, and a copy of the address it was stored at. The checker also sees the live micro-program-counter. On every valid fetch it tests the check value, compares the stored address with the counter, and decides whether the counter stepped by one or took a branch.

Alongside the per-cycle checks, the control fields are folded into a 16-bit multiple-input signature register. When a checkpoint strobe arrives, the accumulated signature is compared with an expected value supplied by the surrounding logic. The register then restarts from its seed. Detected faults raise sticky flags, which stay up until an explicit clear. A two-bit cause code names the most serious flag that is set.

Sequence tracking uses a two-state machine. `TRK_FRESH` is the state after reset, before any fetch has been seen. The first valid fetch moves it to `TRK_FOLLOW` (transition "first fetch"), and it stays in `TRK_FOLLOW` until reset (transition "follow"). A branch is only reported in `TRK_FOLLOW`.

Top module: `useq_guard`

## Requirements
- R1: On a valid fetch, the check bits must equal the number of zero bits in the control field, as an unsigned binary count of ceil(log2(CTRL_W+1)) bits (5 bits for 16 control bits). A mismatch sets `err_code` one cycle later.
- R2: On a valid fetch whose `tag_addr` differs from `upc`, `err_addr` is set one cycle later.
- R3: `jump_flag` is high for one cycle after a valid fetch whose `upc` is not the previous valid fetch's `upc` plus one, modulo 2^ADDR_W (so 0xFF followed by 0x00 counts as sequential). Otherwise it is low.
- R4: The first valid fetch after reset never raises `jump_flag`.
- R5: The signature starts at all ones. Each valid fetch updates it as s' = (s<<1) ^ (s[15] ? 16'h1021 : 0) ^ f, where f XOR-folds the control field into 16 bits. When `ckpt_stb` is high, the signature over the valid fetches before that cycle is compared with `sig_expect`, and a mismatch sets `err_sig` one cycle later. The register then restarts from all ones, and a fetch in the same cycle is absorbed into the new run.
- R6: While `fetch_vld` is low, bad check bits or a bad address set no flag. That cycle also changes neither the branch tracking nor the signature.
- R7: Flags hold until `err_clr`. A clear takes effect one cycle later, and an error detected in the same cycle as the clear wins over the clear.
- R8: `err_cause` encodes 0 for none, 1 for code, 2 for address and 3 for signature. It reports the highest-priority flag currently set, with code above address above signature.
- R9: After reset all flags, `err_cause` and `jump_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_vld | input | 1 | Marks a real fetch this cycle |
| ctrl_word | input | CTRL_W | Control field of the fetched word |
| chk_bits | input | CHK_W | Berger check value carried with it |
| tag_addr | input | ADDR_W | Address stored inside the word |
| upc | input | ADDR_W | Current micro-program-counter |
| ckpt_stb | input | 1 | Compare and restart the signature |
| sig_expect | input | SIG_W | Expected signature at checkpoint |
| err_clr | input | 1 | Clear sticky flags |
| err_code | output | 1 | Sticky check-code fault |
| err_addr | output | 1 | Sticky sequencing fault |
| err_sig | output | 1 | Sticky signature fault |
| err_cause | output | 2 | Priority cause code |
| jump_flag | output | 1 | Previous fetch was a branch |

## Verification
Every result is a register: flags, cause and branch indication all appear on the first clock edge after the inputs that caused them. The cause follows a flag change within that same cycle. The bench drives inputs at the falling edge, advances its own model at the rising edge, and compares one nanosecond later. Each check therefore sees exactly the edge that consumed the stimulus. The checkpoint compare uses the model's signature from before that edge, so the stimulus sets the expected value from the state one cycle behind.

// File: rtl/useq_pkg.sv
package useq_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_CODE = 2'd1,
        CAUSE_ADDR = 2'd2,
        CAUSE_SIG  = 2'd3
    } cause_e;

    typedef enum logic {
        TRK_FRESH  = 1'b0,
        TRK_FOLLOW = 1'b1
    } trk_state_e;
endpackage

// File: rtl/useq_berger_chk.sv
module useq_berger_chk #(
    parameter int CTRL_W = 16,
    parameter int CHK_W  = $clog2(CTRL_W + 1)
) (
    input  logic [CTRL_W-1:0] word,
    input  logic [CHK_W-1:0]  chk,
    output logic              bad
);
    logic [CHK_W-1:0] zero_cnt;

    always_comb begin
        zero_cnt = '0;
        for (int i = 0; i < CTRL_W; i++) begin
            zero_cnt = zero_cnt + CHK_W'(!word[i]);
        end
        bad = (zero_cnt != chk);
    end
endmodule

// File: rtl/useq_misr.sv
module useq_misr #(
    parameter int              CTRL_W = 16,
    parameter int              SIG_W  = 16,
    parameter logic [SIG_W-1:0] POLY  = 16'h1021
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              absorb,
    input  logic              restart,
    input  logic [CTRL_W-1:0] word,
    output logic [SIG_W-1:0]  sig
);
    logic [SIG_W-1:0] fold;
    logic [SIG_W-1:0] base;
    logic [SIG_W-1:0] sig_nxt;

    always_comb begin
        fold = '0;
        for (int i = 0; i < CTRL_W; i++) begin
            fold[i % SIG_W] = fold[i % SIG_W] ^ word[i];
        end
        base = restart ? '1 : sig;
        if (absorb) begin
            sig_nxt = {base[SIG_W-2:0], 1'b0} ^ (base[SIG_W-1] ? POLY : '0) ^ fold;
        end else begin
            sig_nxt = base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig <= '1;
        else        sig <= sig_nxt;
    end

    AST_MISR_RESEED: assert property (@(posedge clk) disable iff (!rst_n)
        restart && !absorb |=> sig == '1); // R5
    AST_MISR_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !restart && !absorb |=> $stable(sig)); // R6
endmodule

// File: rtl/useq_seq_tracker.sv
module useq_seq_tracker
    import useq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [ADDR_W-1:0] upc,
    output logic              jump_flag
);
    trk_state_e        state, state_nxt;
    logic [ADDR_W-1:0] prev_upc;
    logic              jump_nxt;

    always_comb begin
        state_nxt = state;
        jump_nxt  = 1'b0;
        unique case (state)
            TRK_FRESH: begin
                if (fetch_vld) state_nxt = TRK_FOLLOW;
            end
            TRK_FOLLOW: begin
                jump_nxt = fetch_vld && (upc != prev_upc + ADDR_W'(1));
            end
            default: state_nxt = TRK_FRESH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRK_FRESH;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_upc  <= '0;
            jump_flag <= 1'b0;
        end else begin
            jump_flag <= jump_nxt;
            if (fetch_vld) prev_upc <= upc;
        end
    end

    AST_FIRST_FETCH_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        state == TRK_FRESH |=> !jump_flag); // R4
    AST_JUMP_NEEDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> !jump_flag); // R6
    AST_STEP_NOT_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld && state == TRK_FOLLOW && upc == prev_upc + ADDR_W'(1) |=> !jump_flag); // R3
endmodule

// File: rtl/useq_guard.sv
module useq_guard
    import useq_pkg::*;
#(
    parameter int CTRL_W = 16,
    parameter int ADDR_W = 8,
    parameter int SIG_W  = 16,
    localparam int CHK_W = $clog2(CTRL_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_vld,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic [CHK_W-1:0]  chk_bits,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic [ADDR_W-1:0] upc,
    input  logic              ckpt_stb,
    input  logic [SIG_W-1:0]  sig_expect,
    input  logic              err_clr,
    output logic              err_code,
    output logic              err_addr,
    output logic              err_sig,
    output logic [1:0]        err_cause,
    output logic              jump_flag
);
    logic             berger_bad;
    logic [SIG_W-1:0] sig_now;
    logic             hit_code, hit_addr, hit_sig;
    cause_e           cause;

    useq_berger_chk #(.CTRL_W(CTRL_W), .CHK_W(CHK_W)) berger_i (
        .word (ctrl_word),
        .chk  (chk_bits),
        .bad  (berger_bad)
    );

    useq_misr #(.CTRL_W(CTRL_W), .SIG_W(SIG_W)) misr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .absorb  (fetch_vld),
        .restart (ckpt_stb),
        .word    (ctrl_word),
        .sig     (sig_now)
    );

    useq_seq_tracker #(.ADDR_W(ADDR_W)) trk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_vld (fetch_vld),
        .upc       (upc),
        .jump_flag (jump_flag)
    );

    assign hit_code = fetch_vld && berger_bad;
    assign hit_addr = fetch_vld && (tag_addr != upc);
    assign hit_sig  = ckpt_stb && (sig_now != sig_expect);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_code <= 1'b0;
            err_addr <= 1'b0;
            err_sig  <= 1'b0;
        end else if (err_clr) begin
            err_code <= hit_code;
            err_addr <= hit_addr;
            err_sig  <= hit_sig;
        end else begin
            err_code <= err_code | hit_code;
            err_addr <= err_addr | hit_addr;
            err_sig  <= err_sig  | hit_sig;
        end
    end

    always_comb begin
        if (err_code)      cause = CAUSE_CODE;
        else if (err_addr) cause = CAUSE_ADDR;
        else if (err_sig)  cause = CAUSE_SIG;
        else               cause = CAUSE_NONE;
        err_cause = cause;
    end

    AST_ADDR_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld && (tag_addr != upc) |=> err_addr); // R2
    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        err_code && !err_clr |=> err_code); // R7
    AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !fetch_vld && !ckpt_stb |=> !err_code && !err_addr && !err_sig); // R7
    AST_NO_FETCH_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld && !err_code |=> !err_code); // R6
endmodule

// File: tb/useq_guard_tb.sv
module useq_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 1'b0;
    logic [15:0] ctrl_word = '0;
    logic [4:0]  chk_bits = '0;
    logic [7:0]  tag_addr = '0;
    logic [7:0]  upc = '0;
    logic        ckpt_stb = 1'b0;
    logic [15:0] sig_expect = '0;
    logic        err_clr = 1'b0;
    logic        err_code, err_addr, err_sig, jump_flag;
    logic [1:0]  err_cause;

    int total = 0;
    int bad = 0;
    bit done = 0;
    string phase = "init";

    bit        m_code, m_addr, m_sig, m_jump, m_have;
    logic [7:0]  m_prev;
    logic [15:0] m_sigreg;

    always #5 clk = ~clk;

    useq_guard dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .ctrl_word(ctrl_word),
        .chk_bits(chk_bits), .tag_addr(tag_addr), .upc(upc), .ckpt_stb(ckpt_stb),
        .sig_expect(sig_expect), .err_clr(err_clr), .err_code(err_code),
        .err_addr(err_addr), .err_sig(err_sig), .err_cause(err_cause),
        .jump_flag(jump_flag)
    );

    function automatic logic [4:0] zeros_of(input logic [15:0] w);
        return 5'(16 - $countones(w));
    endfunction

    function automatic logic [15:0] sig_step(input logic [15:0] s, input logic [15:0] w);
        logic [15:0] r;
        r = s << 1;
        if (s[15]) r = r ^ 16'h1021;
        return r ^ w;
    endfunction

    function automatic logic [1:0] cause_of(input bit c, input bit a, input bit s);
        return c ? 2'd1 : a ? 2'd2 : s ? 2'd3 : 2'd0;
    endfunction

    task automatic check(input string req, input string what, input logic [15:0] act,
                         input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s/%s: %s got %0h exp %0h", req, phase, what, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [15:0] cw, input bit badchk,
                        input logic [7:0] pc, input bit badtag, input bit ck,
                        input bit badsig, input bit clr);
        bit bc, ba, bs;
        logic [15:0] base;
        @(negedge clk);
        fetch_vld  = v;
        ctrl_word  = cw;
        chk_bits   = zeros_of(cw) ^ (badchk ? 5'd1 : 5'd0);
        upc        = pc;
        tag_addr   = badtag ? (pc ^ 8'h5A) : pc;
        ckpt_stb   = ck;
        sig_expect = badsig ? (m_sigreg ^ 16'h0001) : m_sigreg;
        err_clr    = clr;
        @(posedge clk);
        #1;
        bc = v && badchk;
        ba = v && badtag;
        bs = ck && badsig;
        if (clr) begin
            m_code = bc; m_addr = ba; m_sig = bs;
        end else begin
            m_code = m_code | bc; m_addr = m_addr | ba; m_sig = m_sig | bs;
        end
        m_jump = v && m_have && (pc != m_prev + 8'd1);
        if (v) begin
            m_have = 1; m_prev = pc;
        end
        base = ck ? 16'hFFFF : m_sigreg;
        m_sigreg = v ? sig_step(base, cw) : base;
        check("R3", "jump_flag", 16'(jump_flag), 16'(m_jump));
        check("R1", "err_code", 16'(err_code), 16'(m_code));
        check("R2", "err_addr", 16'(err_addr), 16'(m_addr));
        check("R5", "err_sig", 16'(err_sig), 16'(m_sig));
        check("R8", "err_cause", 16'(err_cause), 16'(cause_of(m_code, m_addr, m_sig)));
    endtask

    task automatic idle();
        step(0, 16'h0, 0, 8'h0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run got hung exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [7:0] pc;
        m_code = 0; m_addr = 0; m_sig = 0; m_jump = 0; m_have = 0;
        m_prev = 0; m_sigreg = 16'hFFFF;
        seed = $urandom(32'd1234);
        repeat (3) @(posedge clk);
        #1;
        phase = "R9";
        check("R9", "err_code", 16'(err_code), 16'd0);
        check("R9", "err_addr", 16'(err_addr), 16'd0);
        check("R9", "err_sig", 16'(err_sig), 16'd0);
        check("R9", "err_cause", 16'(err_cause), 16'd0);
        check("R9", "jump_flag", 16'(jump_flag), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();

        phase = "R4";
        step(1, 16'hA5C3, 0, 8'h37, 0, 0, 0, 0);
        phase = "R3";
        step(1, 16'h0001, 0, 8'h38, 0, 0, 0, 0);
        step(1, 16'hFFFF, 0, 8'h80, 0, 0, 0, 0);
        step(1, 16'h0000, 0, 8'hFF, 0, 0, 0, 0);
        step(1, 16'h1234, 0, 8'h00, 0, 0, 0, 0);

        phase = "R6";
        step(0, 16'h5555, 1, 8'h90, 1, 0, 0, 0);
        step(1, 16'h4321, 0, 8'h01, 0, 0, 0, 0);

        phase = "R5";
        step(0, 16'h0, 0, 8'h0, 0, 1, 0, 0);
        step(1, 16'hBEEF, 0, 8'h02, 0, 0, 0, 0);
        step(1, 16'hCAFE, 0, 8'h03, 0, 1, 1, 0);

        phase = "R7";
        step(0, 16'h0, 0, 8'h0, 0, 0, 0, 1);
        step(1, 16'h0F0F, 1, 8'h04, 0, 0, 0, 0);
        idle();
        step(1, 16'h0F0F, 0, 8'h05, 1, 0, 0, 1);
        step(0, 16'h0, 0, 8'h0, 0, 0, 0, 1);

        phase = "R8";
        step(1, 16'h7777, 1, 8'h06, 1, 1, 1, 0);
        step(0, 16'h0, 0, 8'h0, 0, 1, 1, 1);
        step(1, 16'h8888, 0, 8'h07, 1, 0, 0, 1);
        step(0, 16'h0, 0, 8'h0, 0, 0, 0, 1);

        phase = "rand";
        pc = 8'h07;
        for (int i = 0; i < 3000; i++) begin
            bit v, bchk, btag, ck, bsig, clr;
            logic [15:0] w;
            v    = ($urandom % 4) != 0;
            w    = 16'($urandom);
            bchk = ($urandom % 40) == 0;
            btag = ($urandom % 40) == 0;
            ck   = ($urandom % 25) == 0;
            bsig = ($urandom % 3) == 0;
            clr  = ($urandom % 30) == 0;
            if (v) pc = (($urandom % 5) == 0) ? 8'($urandom) : pc + 8'd1;
            step(v, w, bchk, pc, btag, ck, bsig, clr);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule